// File: doc/BRIEF.md
# Directory Entry Busy-State Controller

This block holds the home-node directory state for a small set of cache lines in a directory-based coherence protocol. Each line is either uncached, held exclusive by one processor, or busy while a forwarded request is outstanding. Messages arrive one per cycle: read or write requests from processors, writebacks from owners, and confirmations that exclusive ownership has passed to a new processor. For each message the block answers with at most one message, which may be a forward to the current owner, a data reply, an ACK or a NACK. Every answer carries a destination ID and the ID of the processor being served.

The block resolves the race between a forwarded request and a writeback from the old owner. A request for a line that another processor owns puts the line into busy and records the requester as pending. The line stays busy until one of two things happens. If the old owner writes back, the directory serves the pending requester from the written-back data. If the new owner confirms the transfer, the line becomes exclusive to it. While the line is busy, new requests get a NACK and must retry. A writeback from the not-yet-confirmed new owner also gets a NACK.

Top module: `dir_busy_ctrl`

## Requirements
- R1: After reset every line is uncached and `out_valid` is low; the first request to any line gets a data reply.
- R2: A read (in_kind 0) or write (in_kind 1) request to an uncached line gets a data reply (out_kind 2) with destination and requester equal to the sender, and the line becomes exclusive to the sender.
- R3: A request to a line held exclusive by a different processor gets a forward (out_kind 1) with destination equal to the owner and requester equal to the sender, and the line becomes busy with the sender pending.
- R4: Any request to a busy line gets a NACK (out_kind 4) with destination and requester equal to the sender, and the line's state is unchanged.
- R5: A writeback (in_kind 2) from the old owner of a busy line gets a data reply to the pending requester (destination and requester both equal to the pending ID), and the line becomes exclusive to that requester.
- R6: A writeback from the pending requester of a busy line gets a NACK to that requester, and the line stays busy.
- R7: A transfer confirmation (in_kind 3) from the pending requester of a busy line makes it the exclusive owner and produces no output message. A confirmation from any other processor is ignored, and the line stays busy.
- R8: A writeback from the owner of an exclusive line gets an ACK (out_kind 3) to the owner, and the line becomes uncached.
- R9: On a line that is not busy, a writeback from a non-owner gets a NACK, and a transfer confirmation produces no output; neither changes the line.
- R10: A request from the current owner of an exclusive line gets a data reply to the owner, and the line stays exclusive to it.
- R11: Each answer appears on the outputs in the cycle after the input message. `out_valid` is low, and out_kind is 0, in any cycle after a cycle with no input message. Lines are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input message is present this cycle |
| in_kind | input | 2 | 0 read, 1 write, 2 writeback, 3 transfer confirmation |
| in_src | input | ID_W | Sending processor ID |
| in_line | input | LINE_W | Line index addressed by the message |
| out_valid | output | 1 | An output message is present |
| out_kind | output | 3 | 0 none, 1 forward, 2 data, 3 ACK, 4 NACK |
| out_dst | output | ID_W | Destination processor ID |
| out_req | output | ID_W | Requester being served |

## Verification
Every answer is registered, so the answer to a message driven before clock edge N is due just after edge N. The bench drives each message on a falling edge and removes it right after the next rising edge. It samples the outputs one time unit after that rising edge, so it reads exactly the answer to the message it just sent. A quiet cycle is checked in the same way, one edge after no input, where the outputs must be idle. State changes that produce no output are observed through the answer to the next request on that line.

// File: rtl/dir_busy_pkg.sv
package dir_busy_pkg;
   typedef enum logic [1:0] {
      IN_RD   = 2'd0,
      IN_WR   = 2'd1,
      IN_WB   = 2'd2,
      IN_XACK = 2'd3
   } in_kind_e;

   typedef enum logic [2:0] {
      OUT_NONE = 3'd0,
      OUT_FWD  = 3'd1,
      OUT_DATA = 3'd2,
      OUT_ACK  = 3'd3,
      OUT_NACK = 3'd4
   } out_kind_e;

   typedef enum logic [1:0] {
      LN_UNC  = 2'd0,
      LN_EXC  = 2'd1,
      LN_BUSY = 2'd2
   } line_st_e;
endpackage

// File: rtl/dir_entry_bank.sv
module dir_entry_bank
   import dir_busy_pkg::*;
#(
   parameter int NUM_LINES = 4,
   parameter int ID_W      = 3,
   localparam int LINE_W   = $clog2(NUM_LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] rd_line,
   output line_st_e          rd_st,
   output logic [ID_W-1:0]   rd_owner,
   output logic [ID_W-1:0]   rd_pend,
   input  logic              wr_en,
   input  logic [LINE_W-1:0] wr_line,
   input  line_st_e          wr_st,
   input  logic [ID_W-1:0]   wr_owner,
   input  logic [ID_W-1:0]   wr_pend
);
   line_st_e        st_q    [NUM_LINES];
   logic [ID_W-1:0] owner_q [NUM_LINES];
   logic [ID_W-1:0] pend_q  [NUM_LINES];

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      logic hit;
      assign hit = wr_en && (wr_line == LINE_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q[g]    <= LN_UNC;
            owner_q[g] <= '0;
            pend_q[g]  <= '0;
         end else if (hit) begin
            st_q[g]    <= wr_st;
            owner_q[g] <= wr_owner;
            pend_q[g]  <= wr_pend;
         end
      end
   end

   assign rd_st    = st_q[rd_line];
   assign rd_owner = owner_q[rd_line];
   assign rd_pend  = pend_q[rd_line];
endmodule

// File: rtl/dir_transition.sv
module dir_transition
   import dir_busy_pkg::*;
#(
   parameter int ID_W = 3
) (
   input  logic            in_valid,
   input  in_kind_e        in_kind,
   input  logic [ID_W-1:0] in_src,
   input  line_st_e        cur_st,
   input  logic [ID_W-1:0] cur_owner,
   input  logic [ID_W-1:0] cur_pend,
   output logic            upd,
   output line_st_e        nxt_st,
   output logic [ID_W-1:0] nxt_owner,
   output logic [ID_W-1:0] nxt_pend,
   output logic            msg_valid,
   output out_kind_e       msg_kind,
   output logic [ID_W-1:0] msg_dst,
   output logic [ID_W-1:0] msg_req
);
   logic is_req;
   logic from_owner;
   logic from_pend;

   assign is_req     = (in_kind == IN_RD) || (in_kind == IN_WR);
   assign from_owner = (in_src == cur_owner);
   assign from_pend  = (in_src == cur_pend);

   always_comb begin
      upd       = 1'b0;
      nxt_st    = cur_st;
      nxt_owner = cur_owner;
      nxt_pend  = cur_pend;
      msg_valid = 1'b0;
      msg_kind  = OUT_NONE;
      msg_dst   = in_src;
      msg_req   = in_src;
      if (in_valid) begin
         unique case (cur_st)
            LN_UNC: begin
               if (is_req) begin
                  upd       = 1'b1;
                  nxt_st    = LN_EXC;
                  nxt_owner = in_src;
                  msg_valid = 1'b1;
                  msg_kind  = OUT_DATA;
               end else if (in_kind == IN_WB) begin
                  msg_valid = 1'b1;
                  msg_kind  = OUT_NACK;
               end
            end
            LN_EXC: begin
               if (is_req) begin
                  msg_valid = 1'b1;
                  if (from_owner) begin
                     msg_kind = OUT_DATA;
                  end else begin
                     upd      = 1'b1;
                     nxt_st   = LN_BUSY;
                     nxt_pend = in_src;
                     msg_kind = OUT_FWD;
                     msg_dst  = cur_owner;
                  end
               end else if (in_kind == IN_WB) begin
                  msg_valid = 1'b1;
                  if (from_owner) begin
                     upd      = 1'b1;
                     nxt_st   = LN_UNC;
                     msg_kind = OUT_ACK;
                  end else begin
                     msg_kind = OUT_NACK;
                  end
               end
            end
            LN_BUSY: begin
               if (is_req) begin
                  msg_valid = 1'b1;
                  msg_kind  = OUT_NACK;
               end else if (in_kind == IN_WB) begin
                  msg_valid = 1'b1;
                  if (from_owner) begin
                     upd       = 1'b1;
                     nxt_st    = LN_EXC;
                     nxt_owner = cur_pend;
                     msg_kind  = OUT_DATA;
                     msg_dst   = cur_pend;
                     msg_req   = cur_pend;
                  end else begin
                     msg_kind = OUT_NACK;
                  end
               end else if (from_pend) begin
                  upd       = 1'b1;
                  nxt_st    = LN_EXC;
                  nxt_owner = cur_pend;
               end
            end
            default: begin
               upd    = 1'b1;
               nxt_st = LN_UNC;
            end
         endcase
      end
   end
endmodule

// File: rtl/dir_msg_stage.sv
module dir_msg_stage
   import dir_busy_pkg::*;
#(
   parameter int ID_W    = 3,
   parameter bit REG_OUT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            msg_valid,
   input  out_kind_e       msg_kind,
   input  logic [ID_W-1:0] msg_dst,
   input  logic [ID_W-1:0] msg_req,
   output logic            out_valid,
   output out_kind_e       out_kind,
   output logic [ID_W-1:0] out_dst,
   output logic [ID_W-1:0] out_req
);
   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_kind  <= OUT_NONE;
            out_dst   <= '0;
            out_req   <= '0;
         end else begin
            out_valid <= msg_valid;
            out_kind  <= msg_kind;
            out_dst   <= msg_dst;
            out_req   <= msg_req;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign out_valid  = msg_valid;
      assign out_kind   = msg_kind;
      assign out_dst    = msg_dst;
      assign out_req    = msg_req;
   end
endmodule

// File: rtl/dir_busy_ctrl.sv
module dir_busy_ctrl
   import dir_busy_pkg::*;
#(
   parameter int NUM_LINES = 4,
   parameter int ID_W      = 3,
   localparam int LINE_W   = $clog2(NUM_LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        in_kind,
   input  logic [ID_W-1:0]   in_src,
   input  logic [LINE_W-1:0] in_line,
   output logic              out_valid,
   output logic [2:0]        out_kind,
   output logic [ID_W-1:0]   out_dst,
   output logic [ID_W-1:0]   out_req
);
   if (NUM_LINES < 2 || (1 << LINE_W) != NUM_LINES) begin : g_bad_lines
      $error("NUM_LINES must be a power of two of at least 2");
   end
   if (ID_W < 1 || ID_W > 8) begin : g_bad_id
      $error("ID_W must lie between 1 and 8");
   end

   line_st_e        cur_st, nxt_st;
   logic [ID_W-1:0] cur_owner, cur_pend, nxt_owner, nxt_pend;
   logic            upd;
   logic            msg_valid;
   out_kind_e       msg_kind, out_kind_e_w;
   logic [ID_W-1:0] msg_dst, msg_req;

   dir_entry_bank #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_line  (in_line),
      .rd_st    (cur_st),
      .rd_owner (cur_owner),
      .rd_pend  (cur_pend),
      .wr_en    (upd),
      .wr_line  (in_line),
      .wr_st    (nxt_st),
      .wr_owner (nxt_owner),
      .wr_pend  (nxt_pend)
   );

   dir_transition #(.ID_W(ID_W)) u_fsm (
      .in_valid  (in_valid),
      .in_kind   (in_kind_e'(in_kind)),
      .in_src    (in_src),
      .cur_st    (cur_st),
      .cur_owner (cur_owner),
      .cur_pend  (cur_pend),
      .upd       (upd),
      .nxt_st    (nxt_st),
      .nxt_owner (nxt_owner),
      .nxt_pend  (nxt_pend),
      .msg_valid (msg_valid),
      .msg_kind  (msg_kind),
      .msg_dst   (msg_dst),
      .msg_req   (msg_req)
   );

   dir_msg_stage #(.ID_W(ID_W), .REG_OUT(1'b1)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .msg_valid (msg_valid),
      .msg_kind  (msg_kind),
      .msg_dst   (msg_dst),
      .msg_req   (msg_req),
      .out_valid (out_valid),
      .out_kind  (out_kind_e_w),
      .out_dst   (out_dst),
      .out_req   (out_req)
   );

   assign out_kind = out_kind_e_w;
endmodule

// File: rtl/dir_busy_ctrl_chk.sv
module dir_busy_ctrl_chk #(
   parameter int ID_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [1:0]      in_kind,
   input logic [ID_W-1:0] in_src,
   input logic            out_valid,
   input logic [2:0]      out_kind,
   input logic [ID_W-1:0] out_dst,
   input logic [ID_W-1:0] out_req
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && out_kind == 3'd0)); // R11
   AST_ANSWER_DUE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_kind != 2'd3) |=> out_valid); // R11
   AST_XFER_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_kind == 2'd3) |=> !out_valid); // R7
   AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_kind >= 3'd1 && out_kind <= 3'd4)); // R11
   AST_FWD_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind == 3'd1) |-> (out_dst != out_req)); // R3
   AST_DATA_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind == 3'd2) |-> (out_dst == out_req)); // R2
   AST_NACK_TO_SENDER: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ((out_kind == 3'd4) -> (out_dst == $past(in_src)))); // R4
   AST_REQ_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_kind[1] == 1'b0) |=> (out_kind != 3'd3)); // R2
   AST_WB_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_kind == 2'd2) |=> (out_kind != 3'd1)); // R8
endmodule

bind dir_busy_ctrl dir_busy_ctrl_chk #(.ID_W(ID_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_kind   (in_kind),
   .in_src    (in_src),
   .out_valid (out_valid),
   .out_kind  (out_kind),
   .out_dst   (out_dst),
   .out_req   (out_req)
);

// File: tb/tb_dir_busy_ctrl.sv
module tb_dir_busy_ctrl;
   localparam int ID_W   = 3;
   localparam int NL     = 4;
   localparam int LW     = 2;
   localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_WB = 2'd2, K_XA = 2'd3;
   localparam logic [2:0] O_NONE = 3'd0, O_FWD = 3'd1, O_DATA = 3'd2, O_ACK = 3'd3, O_NACK = 3'd4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [1:0]      in_kind = '0;
   logic [ID_W-1:0] in_src = '0;
   logic [LW-1:0]   in_line = '0;
   logic            out_valid;
   logic [2:0]      out_kind;
   logic [ID_W-1:0] out_dst, out_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dir_busy_ctrl #(.NUM_LINES(NL), .ID_W(ID_W)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
      .in_src(in_src), .in_line(in_line), .out_valid(out_valid),
      .out_kind(out_kind), .out_dst(out_dst), .out_req(out_req)
   );

   task automatic expect_out(input string tag, input logic ev, input logic [2:0] ek,
                             input logic [ID_W-1:0] ed, input logic [ID_W-1:0] er);
      checks++;
      if (out_valid !== ev || out_kind !== ek ||
          (ev && (out_dst !== ed || out_req !== er))) begin
         errors++;
         $display("FAIL %s: got v=%0b k=%0d d=%0d r=%0d, expected v=%0b k=%0d d=%0d r=%0d",
                  tag, out_valid, out_kind, out_dst, out_req, ev, ek, ed, er);
      end
   endtask

   task automatic xact(input logic [1:0] k, input int src, input int ln, input string tag,
                       input logic ev, input logic [2:0] ek, input int ed, input int er);
      @(negedge clk);
      in_valid = 1'b1;
      in_kind  = k;
      in_src   = ID_W'(src);
      in_line  = LW'(ln);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      expect_out(tag, ev, ek, ID_W'(ed), ID_W'(er));
   endtask

   task automatic t_reset();
      @(negedge clk);
      expect_out("R1 idle after reset", 1'b0, O_NONE, 0, 0);
      xact(K_RD, 1, 0, "R1 first request served", 1'b1, O_DATA, 1, 1);
   endtask

   task automatic t_grant();
      xact(K_RD, 2, 1, "R2 grant uncached", 1'b1, O_DATA, 2, 2);
      xact(K_WR, 2, 1, "R10 owner re-request", 1'b1, O_DATA, 2, 2);
   endtask

   task automatic t_handoff();
      xact(K_WR, 5, 1, "R3 forward to owner", 1'b1, O_FWD, 2, 5);
      xact(K_RD, 6, 1, "R4 busy nack", 1'b1, O_NACK, 6, 6);
      xact(K_XA, 6, 1, "R7 stray confirm silent", 1'b0, O_NONE, 0, 0);
      xact(K_WR, 7, 1, "R7 still busy after stray confirm", 1'b1, O_NACK, 7, 7);
      xact(K_WB, 5, 1, "R6 new owner writeback nack", 1'b1, O_NACK, 5, 5);
      xact(K_XA, 5, 1, "R7 confirm silent", 1'b0, O_NONE, 0, 0);
      xact(K_RD, 3, 1, "R7 new owner recorded", 1'b1, O_FWD, 5, 3);
   endtask

   task automatic t_wb_race();
      xact(K_WB, 5, 1, "R5 writeback serves pending", 1'b1, O_DATA, 3, 3);
      xact(K_WB, 3, 1, "R8 owner writeback ack", 1'b1, O_ACK, 3, 3);
      xact(K_RD, 4, 1, "R8 line uncached again", 1'b1, O_DATA, 4, 4);
   endtask

   task automatic t_non_owner();
      xact(K_WB, 1, 2, "R9 writeback to uncached nack", 1'b1, O_NACK, 1, 1);
      xact(K_XA, 1, 2, "R9 confirm on uncached silent", 1'b0, O_NONE, 0, 0);
      xact(K_RD, 1, 2, "R9 uncached line unchanged", 1'b1, O_DATA, 1, 1);
      xact(K_WB, 2, 2, "R9 non-owner writeback nack", 1'b1, O_NACK, 2, 2);
      xact(K_XA, 4, 2, "R9 confirm on exclusive silent", 1'b0, O_NONE, 0, 0);
      xact(K_RD, 6, 2, "R9 owner unchanged", 1'b1, O_FWD, 1, 6);
   endtask

   task automatic t_independent();
      xact(K_WR, 0, 3, "R11 other line independent", 1'b1, O_DATA, 0, 0);
      @(negedge clk);
      @(posedge clk);
      #1;
      expect_out("R11 quiet after no input", 1'b0, O_NONE, 0, 0);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1;
      rst_n = 1'b1;
      t_reset();
      t_grant();
      t_handoff();
      t_wb_race();
      t_non_owner();
      t_independent();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(5 * 100000);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule